// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block links two 8-bit buses, A and B. Each transfer direction owns a storage register with its own capture clock. A per-direction select line lets the receiving bus see either the live word from the opposite bus or the word captured earlier. Each bus appears as three signals: an input, an output and an output enable. This keeps the design free of tristate nets. The surrounding pad logic merges the three into a real bidirectional pin.

An active-low output enable together with a direction input decides which single bus, if any, the block drives. While the enable is high the block is isolated and drives neither bus. Both registers keep capturing on their clocks during isolation. Words can therefore be parked and replayed later. A build-time parameter inverts every outgoing word, both live and stored. The registers always hold the true bus value.

Top module: `rbt_transceiver`

## Requirements
- R1: On each rising edge of `cap_ab_clk_i`, the A-side register takes the value of `a_i`. It holds that value until the next such edge or reset.
- R2: On each rising edge of `cap_ba_clk_i`, the B-side register takes the value of `b_i`. It holds that value until the next such edge or reset.
- R3: `b_o` equals `a_i` when `sel_ab_i` is 0 (live). It equals the A-side register when `sel_ab_i` is 1 (stored). The selection is combinational.
- R4: `a_o` equals `b_i` when `sel_ba_i` is 0 (live). It equals the B-side register when `sel_ba_i` is 1 (stored). The selection is combinational.
- R5: With `oe_ni` low, `dir_i` = 1 gives `b_oe_o` = 1 and `a_oe_o` = 0. With `oe_ni` low, `dir_i` = 0 gives `a_oe_o` = 1 and `b_oe_o` = 0.
- R6: `a_oe_o` and `b_oe_o` are never 1 together.
- R7: With `oe_ni` high, both enables are 0. Both registers still capture on their clocks, independently of `dir_i` and the select lines.
- R8: With `INVERT` = 1, `a_o` and `b_o` are the bitwise inverse of the selected word on both the live and stored paths. The registers still store the true bus value.
- R9: While `rst_ni` is low, both registers are cleared to zero, asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous active-low reset of both registers |
| cap_ab_clk_i | input | 1 | Capture clock of the A-side register |
| cap_ba_clk_i | input | 1 | Capture clock of the B-side register |
| sel_ab_i | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | Source for bus A: 0 live B, 1 stored B |
| dir_i | input | 1 | 1: A drives B, 0: B drives A |
| oe_ni | input | 1 | Active-low output enable; high isolates both buses |
| a_i | input | WIDTH | Value seen on bus A |
| a_o | output | WIDTH | Word presented to bus A |
| a_oe_o | output | 1 | Drive enable for bus A |
| b_i | input | WIDTH | Value seen on bus B |
| b_o | output | WIDTH | Word presented to bus B |
| b_oe_o | output | 1 | Drive enable for bus B |

## Verification
Two functions can fall in the same cycle: a capture edge, and a stored-path read of that same register while its output is enabled. When they coincide, the output must move to the freshly captured word right after the edge. The bench provokes this by raising a capture clock while the matching select is 1. It samples the outputs a few nanoseconds later and compares them against a model register updated at the same edge. Random rounds mix captures, direction changes and isolation. A second instance built with inversion runs against the same model.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/rbt_capture_reg.sv
module rbt_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

  // held word equals the bus value at the previous capture edge
  AST_CAPTURE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> q_o == $past(d_i)); // R1 R2
endmodule

// File: rtl/rbt_path_sel.sv
module rbt_path_sel
  import rbt_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             sel_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] pick;

  always_comb begin
    unique case (src_sel_e'(sel_i))
      SRC_STORED: pick = stored_i;
      default:    pick = live_i;
    endcase
  end

  generate
    if (INVERT) begin : g_inv
      assign word_o = ~pick;
    end else begin : g_true
      assign word_o = pick;
    end
  endgenerate
endmodule

// File: rtl/rbt_drive_ctrl.sv
module rbt_drive_ctrl (
  input  logic oe_ni,
  input  logic dir_i,
  output logic a_oe_o,
  output logic b_oe_o
);
  logic active;

  assign active = ~oe_ni;
  assign b_oe_o = active & dir_i;
  assign a_oe_o = active & ~dir_i;
endmodule

// File: rtl/rbt_transceiver.sv
module rbt_transceiver #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             rst_ni,
  input  logic             cap_ab_clk_i,
  input  logic             cap_ba_clk_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic             dir_i,
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o
);
  localparam logic [WIDTH-1:0] FLIP = INVERT ? {WIDTH{1'b1}} : '0;

  logic [WIDTH-1:0] ab_q;
  logic [WIDTH-1:0] ba_q;

  // registers always hold the true bus value
  rbt_capture_reg #(.WIDTH(WIDTH)) u_reg_ab (
    .clk_i (cap_ab_clk_i),
    .rst_ni(rst_ni),
    .d_i   (a_i),
    .q_o   (ab_q)
  );

  rbt_capture_reg #(.WIDTH(WIDTH)) u_reg_ba (
    .clk_i (cap_ba_clk_i),
    .rst_ni(rst_ni),
    .d_i   (b_i),
    .q_o   (ba_q)
  );

  rbt_path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_sel_to_b (
    .sel_i   (sel_ab_i),
    .live_i  (a_i),
    .stored_i(ab_q),
    .word_o  (b_o)
  );

  rbt_path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_sel_to_a (
    .sel_i   (sel_ba_i),
    .live_i  (b_i),
    .stored_i(ba_q),
    .word_o  (a_o)
  );

  rbt_drive_ctrl u_drive (
    .oe_ni (oe_ni),
    .dir_i (dir_i),
    .a_oe_o(a_oe_o),
    .b_oe_o(b_oe_o)
  );

  always_comb begin
    AST_ONE_DRIVER: assert (!(a_oe_o && b_oe_o)); // R6
    if (oe_ni) begin
      AST_ISOLATE: assert (!a_oe_o && !b_oe_o); // R7
    end else begin
      AST_DIR_SELECT: assert (b_oe_o == dir_i && a_oe_o == !dir_i); // R5
    end
    if (!sel_ab_i) begin
      AST_LIVE_AB: assert (b_o == (a_i ^ FLIP)); // R3 R8
    end
    if (!sel_ba_i) begin
      AST_LIVE_BA: assert (a_o == (b_i ^ FLIP)); // R4 R8
    end
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (ab_q == '0 && ba_q == '0); // R9
    end
  end
endmodule

// File: tb/rbt_transceiver_tb.sv
module rbt_transceiver_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic rst_ni, cap_ab, cap_ba, sel_ab, sel_ba, dir, oe_n;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out, a_out_x, b_out_x;
  logic a_oe, b_oe, a_oe_x, b_oe_x;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] m_ab, m_ba;

  rbt_transceiver #(.WIDTH(W), .INVERT(1'b0)) u_dut (
    .rst_ni(rst_ni), .cap_ab_clk_i(cap_ab), .cap_ba_clk_i(cap_ba),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .dir_i(dir), .oe_ni(oe_n),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe));

  rbt_transceiver #(.WIDTH(W), .INVERT(1'b1)) u_dut_inv (
    .rst_ni(rst_ni), .cap_ab_clk_i(cap_ab), .cap_ba_clk_i(cap_ba),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .dir_i(dir), .oe_ni(oe_n),
    .a_i(a_in), .a_o(a_out_x), .a_oe_o(a_oe_x),
    .b_i(b_in), .b_o(b_out_x), .b_oe_o(b_oe_x));

  function automatic logic [W-1:0] exp_b(input logic s);
    return s ? m_ab : a_in;
  endfunction
  function automatic logic [W-1:0] exp_a(input logic s);
    return s ? m_ba : b_in;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R3", b_out, exp_b(sel_ab));
    chk("R4", a_out, exp_a(sel_ba));
    chk("R8", b_out_x, ~exp_b(sel_ab));
    chk("R8", a_out_x, ~exp_a(sel_ba));
    chk("R5", {6'd0, a_oe, b_oe}, {6'd0, !oe_n && !dir, !oe_n && dir});
    chk("R6", {7'd0, a_oe & b_oe}, 8'd0);
    chk("R8", {6'd0, a_oe_x, b_oe_x}, {6'd0, a_oe, b_oe});
    if (oe_n) chk("R7", {6'd0, a_oe, b_oe}, 8'd0);
  endtask

  // drive inputs after a rising clock edge, optionally pulse capture clocks, then sample
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic sab,
                      input logic sba, input logic d, input logic oen,
                      input logic pab, input logic pba);
    @(posedge clk);
    #1;
    cap_ab = 1'b0; cap_ba = 1'b0;
    a_in = a; b_in = b; sel_ab = sab; sel_ba = sba; dir = d; oe_n = oen;
    #3;
    if (pab) begin cap_ab = 1'b1; m_ab = a_in; end // R1
    if (pba) begin cap_ba = 1'b1; m_ba = b_in; end // R2
    #3;
    check_all();
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_ni = 1'b0; cap_ab = 1'b0; cap_ba = 1'b0;
    sel_ab = 1'b1; sel_ba = 1'b1; dir = 1'b1; oe_n = 1'b0;
    a_in = 8'h3C; b_in = 8'hC3;
    m_ab = '0; m_ba = '0;
    repeat (3) @(posedge clk);
    #5;
    // R9: reset clears stored words
    chk("R9", b_out, 8'h00);
    chk("R9", a_out, 8'h00);
    chk("R9", b_out_x, 8'hFF);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 capture with stored select in the same cycle
    step(8'hA5, 8'h11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R1", b_out, 8'hA5);
    step(8'h00, 8'h11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1", b_out, 8'hA5);
    // R2 capture, A driven from stored B
    step(8'h00, 8'h5E, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2", a_out, 8'h5E);
    // R7 isolation: capture both, then replay
    step(8'h77, 8'h88, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R7", {6'd0, a_oe, b_oe}, 8'd0);
    step(8'h01, 8'h02, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7", b_out, 8'h77);
    step(8'h01, 8'h02, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7", a_out, 8'h88);
    chk("R8", a_out_x, 8'h77);
    // R3 R4 live paths with all-ones and all-zeros
    step(8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3", b_out, 8'hFF);
    chk("R4", a_out, 8'h00);

    for (int i = 0; i < 400; i++) begin
      step(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule